// File: doc/BRIEF.md
# Register-Mapped Ethernet Frame Mailbox

This block is a very small network interface. A host reaches it through a plain register bus and moves frames one byte at a time through data-port registers. It holds one inbound frame and one outbound frame, each in its own byte buffer. Inbound frames arrive on a byte stream with valid, last and ready. Outbound frames leave on a matching byte stream once the host has written the announced number of bytes.

A busy flag stops a new inbound frame from starting until the host has acknowledged the previous event. A single interrupt control register gathers a transmit-done flag, a receive-done flag and a self-test flag, and a level interrupt output follows it. Writing the self-test bit returns the whole device to its reset state and then raises that flag. The self-test flag clears itself when the host reads the register. MAC, PHY, CRC, address filtering and DMA are outside this block.

Top module: `frame_mailbox`

## Requirements
- R1: After reset, busy reads 1, the receive count, the transmit count and the interrupt control register read 0, and `irq` is low.
- R2: Reads return a value in the cycle after `host_rd_en`. Offset 0x00 reads the first identification word (0x4D424F58) and offset 0x04 reads the second (0x45544831). Busy is bit 0 of offset 0x08, the receive count is at 0x0C, the transmit count at 0x10 and interrupt control at 0x14. Offsets 0x18, 0x20 and all unmapped offsets read 0. When read and write enables are both high, only the write takes effect.
- R3: An inbound frame starts only while busy is 0 and the receive count is below MAX_LEN, and `rx_ready` stays low otherwise. When the frame's last byte is taken, the receive count holds the frame length, busy is 1 and bit 1 (receive done) of interrupt control is set.
- R4: A read of offset 0x1C with a nonzero receive count returns the next stored byte in arrival order in bits 7:0 and decrements the count. With a zero count it returns 0 and changes nothing.
- R5: An inbound frame longer than MAX_LEN (1514) bytes is truncated, and its receive count becomes MAX_LEN.
- R6: `irq` is high exactly when any bit of interrupt control is set.
- R7: A read of interrupt control returns its current value and then clears bit 31 (the test bit).
- R8: A write to interrupt control acts on one bit only, checked in priority order. Bit 0 clears transmit done. Otherwise bit 1 clears receive done. Otherwise bit 31 resets counts, pointers and flags and then sets only bit 31. Afterwards busy equals the OR of all interrupt control bits.
- R9: A write to the transmit count stores the value if it is at most MAX_LEN and stores 0 otherwise. Either way, the transmit write position restarts at 0.
- R10: Each write to offset 0x20 stores bits 7:0 of the data. The write that brings the stored byte count up to the transmit count launches the frame, zeroes the transmit count, sets bit 0 (transmit done) and sets busy.
- R11: A launched frame leaves on the tx stream in write order, one byte per cycle in which `tx_ready` is high. `tx_last` is high on the final byte only, and data is held while `tx_ready` is low.
- R12: Writes to offsets 0x00, 0x04, 0x08, 0x0C, 0x18, 0x1C and to unmapped offsets have no effect. Writes to 0x20 have no effect while the transmit count is 0 or while a frame is still streaming out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 6 | Register byte offset |
| host_wr_en | input | 1 | Register write strobe |
| host_wr_data | input | 32 | Register write data |
| host_rd_en | input | 1 | Register read strobe |
| host_rd_data | output | 32 | Read data, valid the cycle after the strobe |
| rx_valid | input | 1 | Inbound byte valid |
| rx_data | input | 8 | Inbound byte |
| rx_last | input | 1 | Final byte of the inbound frame |
| rx_ready | output | 1 | Block takes the inbound byte |
| tx_valid | output | 1 | Outbound byte valid |
| tx_data | output | 8 | Outbound byte |
| tx_last | output | 1 | Final byte of the outbound frame |
| tx_ready | input | 1 | Sink takes the outbound byte |
| irq | output | 1 | Level interrupt |

## Verification
The properties assume that the tx sink and the rx source follow the valid/ready rules. A source keeps a byte presented until `rx_ready` takes it, and no new outbound frame is launched while one is draining. The properties also assume that reads and writes are single-cycle strobes on the register bus.

The stimulus keeps within these assumptions. All bus and stream inputs are driven on the falling edge. `rx_valid` is held until the sampled `rx_ready` allows the byte. Random `tx_ready` patterns only throttle the sink. Random frame lengths and byte values are drawn up to the buffer limit, and directed cases add the one-byte frame, the oversize frame, the out-of-range count and the flag priority orderings.

// File: rtl/fmb_pkg.sv
package fmb_pkg;
    localparam int unsigned HOST_AW = 6;

    localparam logic [HOST_AW-1:0] OFF_ID_HI   = 6'h00;
    localparam logic [HOST_AW-1:0] OFF_ID_LO   = 6'h04;
    localparam logic [HOST_AW-1:0] OFF_BUSY    = 6'h08;
    localparam logic [HOST_AW-1:0] OFF_RX_LEN  = 6'h0C;
    localparam logic [HOST_AW-1:0] OFF_TX_LEN  = 6'h10;
    localparam logic [HOST_AW-1:0] OFF_FLAGS   = 6'h14;
    localparam logic [HOST_AW-1:0] OFF_VECINFO = 6'h18;
    localparam logic [HOST_AW-1:0] OFF_RX_PORT = 6'h1C;
    localparam logic [HOST_AW-1:0] OFF_TX_PORT = 6'h20;

    // interrupt control bit positions (software decodes these)
    localparam int unsigned FLG_TX   = 0;
    localparam int unsigned FLG_RX   = 1;
    localparam int unsigned FLG_TEST = 31;
endpackage

// File: rtl/fmb_byte_buf.sv
module fmb_byte_buf #(
    parameter int unsigned DEPTH = 1514,
    localparam int unsigned AW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/fmb_rx_fill.sv
module fmb_rx_fill #(
    parameter int unsigned MAX_LEN = 1514,
    localparam int unsigned CW     = $clog2(MAX_LEN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          abort,
    input  logic          can_start,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    input  logic          rx_last,
    output logic          rx_ready,
    output logic          buf_we,
    output logic [CW-1:0] buf_waddr,
    output logic [7:0]    buf_wdata,
    output logic          start_o,
    output logic          done_o,
    output logic [CW-1:0] len_o
);
    typedef struct packed {
        logic          active;
        logic [CW-1:0] wptr;
    } fill_t;

    fill_t s_d, s_q;
    logic  fire;
    logic  room;

    assign rx_ready  = s_q.active | can_start;
    assign fire      = rx_valid & rx_ready;
    assign room      = s_q.wptr < CW'(MAX_LEN);
    assign start_o   = fire & ~s_q.active;
    assign done_o    = fire & rx_last;
    assign len_o     = room ? s_q.wptr + CW'(1) : CW'(MAX_LEN);
    assign buf_waddr = s_q.wptr;
    assign buf_wdata = rx_data;
    assign buf_we    = fire & room & ~abort;

    always_comb begin
        s_d = s_q;
        if (abort) begin
            s_d.active = 1'b0;
            s_d.wptr   = '0;
        end else if (fire) begin
            if (rx_last) begin
                s_d.active = 1'b0;
                s_d.wptr   = '0;
            end else begin
                s_d.active = 1'b1;
                if (room) s_d.wptr = s_q.wptr + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_RX_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (len_o != '0) && (len_o <= CW'(MAX_LEN))); // R5
endmodule

// File: rtl/fmb_tx_stream.sv
module fmb_tx_stream #(
    parameter int unsigned MAX_LEN = 1514,
    localparam int unsigned CW     = $clog2(MAX_LEN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          abort,
    input  logic          start,
    input  logic [CW-1:0] start_len,
    output logic [CW-1:0] buf_raddr,
    input  logic [7:0]    buf_rdata,
    output logic          tx_valid,
    output logic [7:0]    tx_data,
    output logic          tx_last,
    input  logic          tx_ready,
    output logic          active_o
);
    typedef struct packed {
        logic          active;
        logic [CW-1:0] ptr;
        logic [CW-1:0] len;
    } strm_t;

    strm_t s_d, s_q;

    assign buf_raddr = s_q.ptr;
    assign tx_valid  = s_q.active;
    assign tx_data   = buf_rdata;
    assign tx_last   = s_q.active && (s_q.ptr == s_q.len - CW'(1));
    assign active_o  = s_q.active;

    always_comb begin
        s_d = s_q;
        if (abort) begin
            s_d = '0;
        end else if (start) begin
            s_d.active = 1'b1;
            s_d.ptr    = '0;
            s_d.len    = start_len;
        end else if (s_q.active && tx_ready) begin
            if (tx_last) s_d.active = 1'b0;
            else         s_d.ptr    = s_q.ptr + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !abort) |=>
            (tx_valid && $stable(tx_data) && $stable(tx_last))); // R11
endmodule

// File: rtl/frame_mailbox.sv
module frame_mailbox
    import fmb_pkg::*;
#(
    parameter int unsigned MAX_LEN  = 1514,
    parameter logic [31:0] ID_WORD0 = 32'h4D42_4F58,
    parameter logic [31:0] ID_WORD1 = 32'h4554_4831,
    localparam int unsigned CW      = $clog2(MAX_LEN + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic               host_wr_en,
    input  logic [31:0]        host_wr_data,
    input  logic               host_rd_en,
    output logic [31:0]        host_rd_data,
    input  logic               rx_valid,
    input  logic [7:0]         rx_data,
    input  logic               rx_last,
    output logic               rx_ready,
    output logic               tx_valid,
    output logic [7:0]         tx_data,
    output logic               tx_last,
    input  logic               tx_ready,
    output logic               irq
);
    localparam logic [31:0] MAX_LEN32 = 32'(MAX_LEN);
    localparam logic [31:0] TEST_ONLY = 32'h1 << FLG_TEST;

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] rx_count;
        logic [CW-1:0] rx_rptr;
        logic [CW-1:0] tx_count;
        logic [CW-1:0] tx_wptr;
        logic [31:0]   flags;
        logic [31:0]   rd_data;
    } mbox_t;

    mbox_t s_d, s_q;

    logic          soft_rst;
    logic          host_rd;
    logic          txbuf_we;
    logic          tx_start;
    logic          tx_active;
    logic [CW-1:0] tx_raddr;
    logic [7:0]    tx_rdata;
    logic          rxbuf_we;
    logic [CW-1:0] rxbuf_waddr;
    logic [7:0]    rxbuf_wdata;
    logic [7:0]    rx_rdata;
    logic          rx_start;
    logic          rx_done;
    logic [CW-1:0] rx_len;
    logic          rx_can_start;

    assign host_rd  = host_rd_en & ~host_wr_en;
    assign soft_rst = host_wr_en && (host_addr == OFF_FLAGS) &&
                      !host_wr_data[FLG_TX] && !host_wr_data[FLG_RX] &&
                      host_wr_data[FLG_TEST];
    assign rx_can_start = !s_q.busy && (s_q.rx_count < CW'(MAX_LEN));

    fmb_rx_fill #(.MAX_LEN(MAX_LEN)) u_rx_fill (
        .clk       (clk),
        .rst_n     (rst_n),
        .abort     (soft_rst),
        .can_start (rx_can_start),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .rx_last   (rx_last),
        .rx_ready  (rx_ready),
        .buf_we    (rxbuf_we),
        .buf_waddr (rxbuf_waddr),
        .buf_wdata (rxbuf_wdata),
        .start_o   (rx_start),
        .done_o    (rx_done),
        .len_o     (rx_len)
    );

    fmb_byte_buf #(.DEPTH(MAX_LEN)) u_rx_buf (
        .clk   (clk),
        .we    (rxbuf_we),
        .waddr (rxbuf_waddr),
        .wdata (rxbuf_wdata),
        .raddr (s_q.rx_rptr),
        .rdata (rx_rdata)
    );

    fmb_byte_buf #(.DEPTH(MAX_LEN)) u_tx_buf (
        .clk   (clk),
        .we    (txbuf_we),
        .waddr (s_q.tx_wptr),
        .wdata (host_wr_data[7:0]),
        .raddr (tx_raddr),
        .rdata (tx_rdata)
    );

    fmb_tx_stream #(.MAX_LEN(MAX_LEN)) u_tx_stream (
        .clk       (clk),
        .rst_n     (rst_n),
        .abort     (soft_rst),
        .start     (tx_start),
        .start_len (s_q.tx_count),
        .buf_raddr (tx_raddr),
        .buf_rdata (tx_rdata),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .tx_last   (tx_last),
        .tx_ready  (tx_ready),
        .active_o  (tx_active)
    );

    always_comb begin
        s_d         = s_q;
        s_d.rd_data = '0;
        txbuf_we    = 1'b0;
        tx_start    = 1'b0;
        if (host_wr_en) begin
            case (host_addr)
                OFF_TX_LEN: begin
                    s_d.tx_count = (host_wr_data <= MAX_LEN32) ? host_wr_data[CW-1:0] : '0;
                    s_d.tx_wptr  = '0;
                end
                OFF_FLAGS: begin
                    if (host_wr_data[FLG_TX]) begin
                        s_d.flags[FLG_TX] = 1'b0;
                    end else if (host_wr_data[FLG_RX]) begin
                        s_d.flags[FLG_RX] = 1'b0;
                    end else if (soft_rst) begin
                        s_d.rx_count = '0;
                        s_d.rx_rptr  = '0;
                        s_d.tx_count = '0;
                        s_d.tx_wptr  = '0;
                        s_d.flags    = TEST_ONLY;
                    end
                    s_d.busy = |s_d.flags;
                end
                OFF_TX_PORT: begin
                    if (s_q.tx_count != '0 && !tx_active) begin
                        txbuf_we = 1'b1;
                        if (s_q.tx_wptr + CW'(1) == s_q.tx_count) begin
                            tx_start          = 1'b1;
                            s_d.tx_count      = '0;
                            s_d.tx_wptr       = '0;
                            s_d.flags[FLG_TX] = 1'b1;
                            s_d.busy          = 1'b1;
                        end else begin
                            s_d.tx_wptr = s_q.tx_wptr + CW'(1);
                        end
                    end
                end
                default: ;
            endcase
        end else if (host_rd_en) begin
            case (host_addr)
                OFF_ID_HI:  s_d.rd_data = ID_WORD0;
                OFF_ID_LO:  s_d.rd_data = ID_WORD1;
                OFF_BUSY:   s_d.rd_data = {31'd0, s_q.busy};
                OFF_RX_LEN: s_d.rd_data = 32'(s_q.rx_count);
                OFF_TX_LEN: s_d.rd_data = 32'(s_q.tx_count);
                OFF_FLAGS: begin
                    s_d.rd_data         = s_q.flags;
                    s_d.flags[FLG_TEST] = 1'b0;
                end
                OFF_RX_PORT: begin
                    if (s_q.rx_count != '0) begin
                        s_d.rd_data  = {24'd0, rx_rdata};
                        s_d.rx_count = s_q.rx_count - CW'(1);
                        s_d.rx_rptr  = s_q.rx_rptr + CW'(1);
                    end
                end
                default: ;
            endcase
        end
        if (rx_start && !soft_rst) begin
            s_d.rx_count = '0;
            s_d.rx_rptr  = '0;
            s_d.busy     = 1'b1;
        end
        if (rx_done && !soft_rst) begin
            s_d.rx_count      = rx_len;
            s_d.rx_rptr       = '0;
            s_d.flags[FLG_RX] = 1'b1;
            s_d.busy          = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.busy <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign host_rd_data = s_q.rd_data;
    assign irq          = |s_q.flags;

    AST_RX_DONE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !soft_rst) |=> (s_q.busy && s_q.flags[FLG_RX])); // R3
    AST_RX_PORT_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == OFF_RX_PORT && s_q.rx_count != '0 && !rx_start && !rx_done)
            |=> (s_q.rx_count == $past(s_q.rx_count) - CW'(1))); // R4
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.rx_count <= CW'(MAX_LEN)); // R5
    AST_TEST_BIT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == OFF_FLAGS) |=> !s_q.flags[FLG_TEST]); // R7
    AST_TX_LEN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.tx_count <= CW'(MAX_LEN)); // R9
    AST_TX_PTR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.tx_wptr < s_q.tx_count) || (s_q.tx_wptr == '0 && s_q.tx_count == '0)); // R10
endmodule

// File: tb/frame_mailbox_test.sv
`timescale 1ns/1ps
module frame_mailbox_test;
    localparam int MAXL = 1514;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  host_addr = '0;
    logic        host_wr_en = 1'b0;
    logic [31:0] host_wr_data = '0;
    logic        host_rd_en = 1'b0;
    logic [31:0] host_rd_data;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_last = 1'b0;
    logic        rx_ready;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_last;
    logic        tx_ready = 1'b1;
    logic        irq;

    int nchk = 0;
    int nerr = 0;

    logic [7:0] rx_bytes [0:2047];
    logic [7:0] tx_bytes [0:2047];
    logic [7:0] got [$];
    int  n_last = 0;
    int  last_pos = 0;
    int  extra_last = 0;
    bit  ready_rand = 1'b0;
    bit  stall = 1'b0;

    frame_mailbox uut (
        .clk(clk), .rst_n(rst_n),
        .host_addr(host_addr), .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
        .host_rd_en(host_rd_en), .host_rd_data(host_rd_data),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
        .irq(irq)
    );

    always #2 clk = ~clk;

    // tx sink: choose ready for the coming edge, then record the handshake
    always @(negedge clk) begin
        if (stall)           tx_ready = 1'b0;
        else if (ready_rand) tx_ready = 1'($urandom % 2);
        else                 tx_ready = 1'b1;
        if (tx_valid && tx_ready) begin
            got.push_back(tx_data);
            if (tx_last) begin
                n_last++;
                last_pos = got.size();
            end
        end
    end

    function automatic logic [31:0] f_txlen(input logic [31:0] v);
        return (v <= 32'(MAXL)) ? v : 32'd0;
    endfunction

    function automatic logic [31:0] f_flags_wr(input logic [31:0] cur, input logic [31:0] v);
        if (v[0]) return cur & ~32'h1;
        if (v[1]) return cur & ~32'h2;
        if (v[31]) return 32'h8000_0000;
        return cur;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        host_addr = a; host_wr_data = d; host_wr_en = 1'b1;
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        host_addr = a; host_rd_en = 1'b1;
        @(negedge clk);
        host_rd_en = 1'b0;
        d = host_rd_data;
    endtask

    task automatic send_rx(input int len, input int max_wait, output bit accepted);
        int i = 0;
        int waited = 0;
        while (i < len && waited < max_wait) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_data = rx_bytes[i]; rx_last = (i == len - 1);
            if (rx_ready) i++;
            else waited++;
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0;
        accepted = (i == len);
    endtask

    task automatic fill_rx(input int len);
        for (int i = 0; i < len; i++) rx_bytes[i] = 8'($urandom);
    endtask

    task automatic drain_rx(input int n, input string req);
        logic [31:0] v;
        for (int i = 0; i < n; i++) begin
            rd(6'h1C, v);
            chk(req, v, {24'd0, rx_bytes[i]});
        end
    endtask

    task automatic wait_tx(input int target);
        int k = 0;
        while (n_last < target && k < 4000) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic send_tx(input int len);
        logic [31:0] v;
        int base;
        got.delete();
        base = n_last;
        wr(6'h10, 32'(len));
        for (int i = 0; i < len; i++) begin
            tx_bytes[i] = 8'($urandom);
            wr(6'h20, {24'($urandom), tx_bytes[i]});
        end
        rd(6'h10, v);
        chk("R10 tx count zero after launch", v, 0);
        rd(6'h08, v);
        chk("R10 busy after launch", v, 1);
        chk("R10 tx done flag", {31'd0, irq}, 1);
        wait_tx(base + 1);
        chk("R11 one frame", 32'(n_last - base), 1);
        chk("R11 frame length", 32'(got.size()), 32'(len));
        chk("R11 last on final byte", 32'(last_pos), 32'(len));
        for (int i = 0; i < len && i < got.size(); i++)
            chk("R11 tx byte", {24'd0, got[i]}, {24'd0, tx_bytes[i]});
    endtask

    initial begin
        #(4 * 190000);
        nchk++; nerr++;
        $display("FAIL watchdog expired");
        $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] cur;
        bit acc;
        int len;
        void'($urandom(32'd5171));

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq low", {31'd0, irq}, 0);
        rd(6'h08, v); chk("R1 busy", v, 1);
        rd(6'h0C, v); chk("R1 rx count", v, 0);
        rd(6'h10, v); chk("R1 tx count", v, 0);
        rd(6'h14, v); chk("R1 flags", v, 0);

        // R2 map
        rd(6'h00, v); chk("R2 id0", v, 32'h4D42_4F58);
        rd(6'h04, v); chk("R2 id1", v, 32'h4554_4831);
        rd(6'h18, v); chk("R2 info zero", v, 0);
        rd(6'h20, v); chk("R2 tx port zero", v, 0);
        rd(6'h3C, v); chk("R2 unmapped zero", v, 0);
        @(negedge clk);
        host_addr = 6'h10; host_wr_data = 32'd7; host_wr_en = 1'b1; host_rd_en = 1'b1;
        @(negedge clk);
        host_wr_en = 1'b0; host_rd_en = 1'b0;
        chk("R2 write wins read data", host_rd_data, 0);
        rd(6'h10, v); chk("R2 write wins stored", v, 7);
        wr(6'h10, 32'd0);

        // R3 blocked while busy
        fill_rx(4);
        send_rx(4, 12, acc);
        chk("R3 blocked while busy", {31'd0, acc}, 0);
        rd(6'h0C, v); chk("R3 count untouched", v, 0);
        wr(6'h14, 32'd0);
        rd(6'h08, v); chk("R8 busy follows flags", v, 0);

        // random inbound frames
        for (int f = 0; f < 6; f++) begin
            len = (f == 0) ? 1 : 1 + int'($urandom % 48);
            fill_rx(len);
            send_rx(len, 20, acc);
            chk("R3 accepted", {31'd0, acc}, 1);
            chk("R6 irq on rx", {31'd0, irq}, 1);
            rd(6'h0C, v); chk("R3 count is length", v, 32'(len));
            rd(6'h08, v); chk("R3 busy set", v, 1);
            begin
                bit acc2;
                send_rx(2, 6, acc2);
                chk("R3 second frame blocked", {31'd0, acc2}, 0);
            end
            rd(6'h14, v); chk("R3 rx done flag", v, 32'h2);
            drain_rx(len, "R4 rx byte");
            rd(6'h1C, v); chk("R4 empty reads zero", v, 0);
            rd(6'h0C, v); chk("R4 count stays zero", v, 0);
            wr(6'h14, 32'h2);
            chk("R6 irq clear", {31'd0, irq}, 0);
            rd(6'h08, v); chk("R8 busy clear", v, 0);
        end

        // R5 oversize frame
        fill_rx(MAXL + 5);
        send_rx(MAXL + 5, 20, acc);
        rd(6'h0C, v); chk("R5 truncated count", v, 32'(MAXL));
        wr(6'h14, 32'h2);
        send_rx(2, 6, acc);
        chk("R3 full buffer blocks", {31'd0, acc}, 0);
        drain_rx(MAXL, "R5 stored byte");
        rd(6'h0C, v); chk("R5 drained", v, 0);

        // R9 count writes
        for (int i = 0; i < 8; i++) begin
            logic [31:0] w;
            case (i)
                0: w = 32'(MAXL);
                1: w = 32'(MAXL + 1);
                2: w = 32'hFFFF_FFFF;
                default: w = ($urandom % 2) ? 32'($urandom % 2000) : $urandom;
            endcase
            wr(6'h10, w);
            rd(6'h10, v);
            chk("R9 tx count", v, f_txlen(w));
        end
        wr(6'h10, 32'd0);

        // R12 tx port ignored with zero count
        wr(6'h20, 32'hAB);
        repeat (3) @(negedge clk);
        chk("R12 no stream", {31'd0, tx_valid}, 0);
        rd(6'h14, v); chk("R12 no flag", v, 0);

        // random outbound frames
        ready_rand = 1'b1;
        for (int f = 0; f < 6; f++) begin
            len = (f == 0) ? 1 : 1 + int'($urandom % 32);
            send_tx(len);
            wr(6'h14, 32'h1);
            rd(6'h14, v); chk("R8 tx done cleared", v, 0);
        end
        ready_rand = 1'b0;

        // R12 tx port blocked during streaming
        stall = 1'b1;
        got.delete();
        wr(6'h10, 32'd3);
        for (int i = 0; i < 3; i++) begin
            tx_bytes[i] = 8'($urandom);
            wr(6'h20, {24'd0, tx_bytes[i]});
        end
        wr(6'h10, 32'd2);
        wr(6'h20, 32'h5A);
        rd(6'h10, v); chk("R12 write while streaming ignored", v, 2);
        stall = 1'b0;
        wait_tx(n_last + 1);
        chk("R11 stalled frame length", 32'(got.size()), 3);
        for (int i = 0; i < 3 && i < got.size(); i++)
            chk("R11 stalled frame byte", {24'd0, got[i]}, {24'd0, tx_bytes[i]});
        send_tx(2);
        wr(6'h14, 32'h1);

        // R8 priority
        rd(6'h14, cur);
        fill_rx(3);
        wr(6'h14, 32'h0);
        send_rx(3, 10, acc);
        send_tx(1);
        rd(6'h14, cur); chk("R8 both flags", cur, 32'h3);
        wr(6'h14, 32'h3);
        cur = f_flags_wr(cur, 32'h3);
        rd(6'h14, v); chk("R8 bit0 first", v, cur);
        rd(6'h08, v); chk("R8 busy remains", v, 1);
        wr(6'h14, 32'h8000_0002);
        cur = f_flags_wr(cur, 32'h8000_0002);
        rd(6'h14, v); chk("R8 bit1 before test", v, cur);
        rd(6'h08, v); chk("R8 busy off", v, 0);
        rd(6'h0C, v); chk("R8 no reset by combined", v, 3);
        drain_rx(3, "R4 rx byte after priority");

        // R8/R7 test bit
        fill_rx(2);
        send_rx(2, 10, acc);
        wr(6'h10, 32'd5);
        wr(6'h20, 32'h11);
        wr(6'h14, 32'h8000_0000);
        chk("R6 irq on test", {31'd0, irq}, 1);
        rd(6'h0C, v); chk("R8 reset rx count", v, 0);
        rd(6'h10, v); chk("R8 reset tx count", v, 0);
        rd(6'h1C, v); chk("R4 empty after reset", v, 0);
        rd(6'h14, v); chk("R7 read returns test bit", v, f_flags_wr(32'h3, 32'h8000_0000));
        rd(6'h14, v); chk("R7 test bit cleared", v, 0);
        chk("R6 irq after read", {31'd0, irq}, 0);
        rd(6'h08, v); chk("R8 busy until write", v, 1);
        wr(6'h14, 32'h0);
        rd(6'h08, v); chk("R8 ack clears busy", v, 0);

        // R12 read-only and unmapped writes
        fill_rx(4);
        send_rx(4, 10, acc);
        wr(6'h08, 32'h0);
        wr(6'h0C, 32'h0);
        wr(6'h00, 32'h0);
        wr(6'h18, 32'hFFFF);
        wr(6'h1C, 32'h0);
        wr(6'h2C, 32'hFFFF_FFFF);
        rd(6'h08, v); chk("R12 busy not writable", v, 1);
        rd(6'h0C, v); chk("R12 count not writable", v, 4);
        rd(6'h00, v); chk("R12 id not writable", v, 32'h4D42_4F58);
        rd(6'h14, v); chk("R12 flags untouched", v, 32'h2);
        drain_rx(4, "R12 rx port write did not pop");

        repeat (4) @(negedge clk);
        $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule